// File: doc/BRIEF.md
# Multi-Node Channel Path Combiner

This block forms the signal-mixing core of a radio network channel emulator. Each of `NODES` radio nodes feeds one signed 12-bit sample per clock. Every directed pair of distinct nodes (source, destination) is a channel. Each channel is built from one or more paths, and a path delays its source by a whole number of samples and scales it by a fine multiplier and a coarse power-of-two shift. Each destination output is the saturated 14-bit sum of all the paths that end at that node. A node therefore never receives its own transmission.

Most channels carry a single path. The first `MULTI_CH` channels carry `MULTI_TAPS` paths each, which lets them model multipath. Samples keep flowing without a gap while a host rewrites path settings. An update controller with two states handles these writes. `UPD_IDLE` moves to `UPD_LOAD` when a write arrives with a valid path index. `UPD_LOAD` stays in `UPD_LOAD` on another valid write and returns to `UPD_IDLE` when no valid write arrives. Writes to indexes beyond the last path leave the controller in `UPD_IDLE`.

Top module: `chsim_path_combiner`

## Requirements
- R1: After reset every `dst_sample` is 0 and every `dst_ovf` bit is 0. All path scales reset to 0, so outputs stay 0 until a path is written.
- R2: The output of destination k contains no contribution from `src_sample[k]`, whatever the path settings.
- R3: A path with scale s (8-bit unsigned), shift h (4-bit, 0..15) and input x contributes the low 14 bits (two's complement) of ((x*s) shifted left by h) arithmetically shifted right by 8. The path gain is therefore s*2^h/256.
- R4: A path with delay d (4-bit, 0..15) uses the source sample presented d clock edges before the current sample. A delay of 0 uses the current sample.
- R5: Channel numbering: for source i and destination k (i != k), the channel is c = k*(NODES-1) + (i<k ? i : i-1), and path index c is that channel's first tap. Paths NODES*(NODES-1) + m*(MULTI_TAPS-1) + j (0 <= j < MULTI_TAPS-1) are the extra taps of channel m, for m < MULTI_CH. All taps of a channel add into the channel's destination.
- R6: A sample presented at clock edge t shows up on `dst_sample` after edge t + ceil(log2(T)) + 2, where T is the largest path count into any destination. With the default parameters T is 7, so the latency is 5 edges. All destinations have the same latency.
- R7: When the exact sum for a destination exceeds 8191 the output is 8191. When it is below -8192 the output is -8192.
- R8: `dst_ovf[k]` rises on the same edge as the first clamped output of destination k. It then stays at 1 until reset.
- R9: A write (`wr_en` high, valid `wr_path`) replaces the path's delay, scale and shift together. These apply to every sample presented from the second edge after the write edge onward. Earlier samples use the old values, and no sample sees a mix of old and new fields. Writes may come on consecutive cycles.
- R10: A write with `wr_path` >= NODES*(NODES-1) + MULTI_CH*(MULTI_TAPS-1) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per node per cycle |
| rst | input | 1 | Synchronous active-high reset |
| src_sample | input | NODES x 12 | Signed sample of each source node |
| wr_en | input | 1 | Path update strobe |
| wr_path | input | $clog2(NPATH+1) | Index of the path to update |
| wr_delay | input | 4 | New delay in samples |
| wr_scale | input | 8 | New fine scale |
| wr_shift | input | 4 | New coarse left shift |
| dst_sample | output | NODES x 14 | Signed saturated sum for each destination |
| dst_ovf | output | NODES | Sticky saturation flag of each destination |

## Verification
Two functions can act in the same cycle: a path write taking effect, and a sample passing through that same path. The bench provokes this by issuing writes, some back to back, while every source is driving random samples. Its reference model applies each write from the second edge after it. Every output in the cycles around the change must then match exactly, so a design that changes the delay and the scale on different samples, or one edge early or late, shows up as a mismatch. In a second case, saturation and its sticky flag fall on the same edge. These are judged together on every compared output.

// File: rtl/chsim_pkg.sv
package chsim_pkg;

    localparam int SMP_W = 12;
    localparam int OUT_W = 14;
    localparam int DLY_W = 4;
    localparam int SCL_W = 8;
    localparam int SHF_W = 4;
    localparam int FRAC  = 8;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [SCL_W-1:0] scl;
        logic [SHF_W-1:0] shf;
    } path_cfg_t;

    typedef enum logic [0:0] {
        UPD_IDLE = 1'b0,
        UPD_LOAD = 1'b1
    } upd_state_e;

    function automatic int n_chan(int n);
        return n * (n - 1);
    endfunction

    function automatic int n_path(int n, int mc, int mt);
        return n * (n - 1) + mc * (mt - 1);
    endfunction

    function automatic int chan_dst(int c, int n);
        return c / (n - 1);
    endfunction

    function automatic int chan_src(int c, int n);
        int k;
        int r;
        k = c / (n - 1);
        r = c % (n - 1);
        return (r < k) ? r : r + 1;
    endfunction

    function automatic int path_chan(int p, int n, int mt);
        int nch;
        nch = n * (n - 1);
        if (p < nch)
            return p;
        return (mt > 1) ? (p - nch) / (mt - 1) : 0;
    endfunction

    function automatic int dst_terms(int k, int n, int mc, int mt);
        int cnt;
        cnt = n - 1;
        for (int m = 0; m < mc; m++)
            if (chan_dst(m, n) == k)
                cnt = cnt + (mt - 1);
        return cnt;
    endfunction

    function automatic int max_terms(int n, int mc, int mt);
        int best;
        best = 0;
        for (int k = 0; k < n; k++)
            if (dst_terms(k, n, mc, mt) > best)
                best = dst_terms(k, n, mc, mt);
        return best;
    endfunction

    // Path feeding slot s of destination k, or -1 for a padding slot.
    function automatic int slot_path(int k, int s, int n, int mc, int mt);
        int nch;
        int idx;
        int res;
        nch = n * (n - 1);
        res = -1;
        if (s < n - 1) begin
            res = k * (n - 1) + s;
        end else begin
            idx = n - 1;
            for (int p = nch; p < nch + mc * (mt - 1); p++) begin
                if (chan_dst(path_chan(p, n, mt), n) == k) begin
                    if (idx == s && res < 0)
                        res = p;
                    idx = idx + 1;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/chsim_delay_line.sv
module chsim_delay_line
    import chsim_pkg::*;
#(
    parameter int DEPTH = 1 << DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] wp,
    input  logic [SMP_W-1:0] x,
    output logic [SMP_W-1:0] hist [DEPTH]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                hist[i] <= '0;
        end else begin
            hist[wp] <= x;
        end
    end

endmodule

// File: rtl/chsim_path.sv
module chsim_path
    import chsim_pkg::*;
#(
    parameter int DEPTH = 1 << DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] x,
    input  logic [SMP_W-1:0] hist [DEPTH],
    input  logic [DLY_W-1:0] wp,
    input  path_cfg_t        cfg,
    output logic [OUT_W-1:0] contrib
);

    localparam int WIDE = SMP_W + SCL_W + 1 + (1 << SHF_W) - 1;

    logic [DLY_W-1:0] rd_idx;
    logic [SMP_W-1:0] tap_d;
    logic [SMP_W-1:0] tap_q;
    logic [SCL_W-1:0] scl_q;
    logic [SHF_W-1:0] shf_q;

    assign rd_idx = wp - cfg.dly;
    assign tap_d  = (cfg.dly == '0) ? x : hist[rd_idx];

    // Scale and shift travel with the tapped sample so that one sample
    // always sees a single coherent set of path settings.
    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
            scl_q <= '0;
            shf_q <= '0;
        end else begin
            tap_q <= tap_d;
            scl_q <= cfg.scl;
            shf_q <= cfg.shf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            contrib <= '0;
        else
            contrib <= OUT_W'((WIDE'($signed(tap_q)) * WIDE'($signed({1'b0, scl_q}))
                               <<< shf_q) >>> FRAC);
    end

endmodule

// File: rtl/chsim_update_ctl.sv
module chsim_update_ctl
    import chsim_pkg::*;
#(
    parameter int NPATH  = 16,
    parameter int PIDX_W = $clog2(NPATH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_path,
    input  path_cfg_t         wr_cfg,
    output path_cfg_t         cfg [NPATH],
    output upd_state_e        state
);

    upd_state_e        state_nx;
    logic              wr_ok;
    logic [PIDX_W-1:0] hold_idx;
    path_cfg_t         hold_cfg;

    assign wr_ok = wr_en && (wr_path < PIDX_W'(NPATH));

    always_ff @(posedge clk) begin
        if (rst)
            state <= UPD_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            UPD_IDLE: state_nx = wr_ok ? UPD_LOAD : UPD_IDLE;
            UPD_LOAD: state_nx = wr_ok ? UPD_LOAD : UPD_IDLE;
            default:  state_nx = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_idx <= '0;
            hold_cfg <= '0;
        end else if (wr_ok) begin
            hold_idx <= wr_path;
            hold_cfg <= wr_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPATH; p++)
                cfg[p] <= '0;
        end else if (state == UPD_LOAD) begin
            for (int p = 0; p < NPATH; p++)
                if (hold_idx == PIDX_W'(p))
                    cfg[p] <= hold_cfg;
        end
    end

endmodule

// File: rtl/chsim_dest_adder.sv
module chsim_dest_adder
    import chsim_pkg::*;
#(
    parameter int TERMS = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [TERMS-1:0][OUT_W-1:0] terms,
    output logic [OUT_W-1:0]            sum,
    output logic                        ovf
);

    localparam int LEVELS = $clog2(TERMS);
    localparam int P2     = 1 << LEVELS;
    localparam int SW     = OUT_W + LEVELS;
    localparam logic signed [SW-1:0] SAT_HI = SW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

    // Heap layout: node n has children 2n and 2n+1; leaves at P2..2*P2-1.
    logic signed [SW-1:0] heap [1:P2-1];
    logic signed [SW-1:0] val  [2:2*P2-1];
    logic signed [SW-1:0] root;
    logic                 hi;
    logic                 lo;

    always_comb begin
        for (int n = 2; n < P2; n++)
            val[n] = heap[n];
        for (int s = 0; s < TERMS; s++)
            val[P2 + s] = SW'($signed(terms[s]));
        for (int s = TERMS; s < P2; s++)
            val[P2 + s] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 1; n < P2; n++)
                heap[n] <= '0;
        end else begin
            for (int n = 1; n < P2; n++)
                heap[n] <= val[2*n] + val[2*n + 1];
        end
    end

    assign root = heap[1];
    assign hi   = root > SAT_HI;
    assign lo   = root < SAT_LO;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
            ovf <= 1'b0;
        end else begin
            sum <= hi ? SAT_HI[OUT_W-1:0] : (lo ? SAT_LO[OUT_W-1:0] : root[OUT_W-1:0]);
            ovf <= ovf | hi | lo;
        end
    end

endmodule

// File: rtl/chsim_path_combiner.sv
module chsim_path_combiner
    import chsim_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int MULTI_CH   = 2,
    parameter int MULTI_TAPS = 3,
    parameter int PIDX_W     = $clog2(n_path(NODES, MULTI_CH, MULTI_TAPS) + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NODES-1:0][SMP_W-1:0] src_sample,
    input  logic                        wr_en,
    input  logic [PIDX_W-1:0]           wr_path,
    input  logic [DLY_W-1:0]            wr_delay,
    input  logic [SCL_W-1:0]            wr_scale,
    input  logic [SHF_W-1:0]            wr_shift,
    output logic [NODES-1:0][OUT_W-1:0] dst_sample,
    output logic [NODES-1:0]            dst_ovf
);

    localparam int NPATH = n_path(NODES, MULTI_CH, MULTI_TAPS);
    localparam int MAXT  = max_terms(NODES, MULTI_CH, MULTI_TAPS);
    localparam int DEPTH = 1 << DLY_W;

    logic [DLY_W-1:0] wp;
    logic [SMP_W-1:0] hist_all [NODES][DEPTH];
    logic [OUT_W-1:0] contrib_all [NPATH];
    path_cfg_t        cfg_tab [NPATH];
    path_cfg_t        wr_cfg;
    upd_state_e       upd_state;

    assign wr_cfg = {wr_delay, wr_scale, wr_shift};

    // One write pointer serves every source history.
    always_ff @(posedge clk) begin
        if (rst)
            wp <= '0;
        else
            wp <= wp + 1'b1;
    end

    chsim_update_ctl #(
        .NPATH (NPATH),
        .PIDX_W(PIDX_W)
    ) u_upd (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_path(wr_path),
        .wr_cfg (wr_cfg),
        .cfg    (cfg_tab),
        .state  (upd_state)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_src
        chsim_delay_line #(.DEPTH(DEPTH)) u_dly (
            .clk (clk),
            .rst (rst),
            .wp  (wp),
            .x   (src_sample[n]),
            .hist(hist_all[n])
        );
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        localparam int SRC = chan_src(path_chan(p, NODES, MULTI_TAPS), NODES);
        chsim_path #(.DEPTH(DEPTH)) u_path (
            .clk    (clk),
            .rst    (rst),
            .x      (src_sample[SRC]),
            .hist   (hist_all[SRC]),
            .wp     (wp),
            .cfg    (cfg_tab[p]),
            .contrib(contrib_all[p])
        );
    end

    for (genvar k = 0; k < NODES; k++) begin : g_dst
        logic [MAXT-1:0][OUT_W-1:0] leaf;
        for (genvar s = 0; s < MAXT; s++) begin : g_slot
            localparam int SP = slot_path(k, s, NODES, MULTI_CH, MULTI_TAPS);
            if (SP >= 0) begin : g_used
                assign leaf[s] = contrib_all[SP];
            end else begin : g_pad
                assign leaf[s] = '0;
            end
        end
        chsim_dest_adder #(.TERMS(MAXT)) u_add (
            .clk  (clk),
            .rst  (rst),
            .terms(leaf),
            .sum  (dst_sample[k]),
            .ovf  (dst_ovf[k])
        );
    end

endmodule

// File: rtl/chsim_path_combiner_chk.sv
module chsim_path_combiner_chk
    import chsim_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int NPATH  = 16,
    parameter int PIDX_W = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NODES-1:0][OUT_W-1:0] dst_sample,
    input logic [NODES-1:0]            dst_ovf,
    input logic                        wr_en,
    input logic [PIDX_W-1:0]           wr_path,
    input upd_state_e                  upd_state
);

    localparam logic [OUT_W-1:0] TOP_V = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] BOT_V = {1'b1, {(OUT_W-1){1'b0}}};

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dst_sample == '0 && dst_ovf == '0));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((dst_ovf & $past(dst_ovf)) == $past(dst_ovf)));

    // R9
    upd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_path < PIDX_W'(NPATH)) |=> (upd_state == UPD_LOAD));

    // R10
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_path >= PIDX_W'(NPATH)) |=> (upd_state == UPD_IDLE));

    for (genvar k = 0; k < NODES; k++) begin : g_k
        // R7
        ovf_clamp_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(dst_ovf[k]) |-> (dst_sample[k] == TOP_V || dst_sample[k] == BOT_V));
    end

endmodule

bind chsim_path_combiner chsim_path_combiner_chk #(
    .NODES (NODES),
    .NPATH (NPATH),
    .PIDX_W(PIDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dst_sample(dst_sample),
    .dst_ovf   (dst_ovf),
    .wr_en     (wr_en),
    .wr_path   (wr_path),
    .upd_state (upd_state)
);

// File: tb/chsim_path_combiner_tb.sv
module chsim_path_combiner_tb;

    localparam int NODES  = 4;
    localparam int MC     = 2;
    localparam int MT     = 3;
    localparam int NCH    = NODES * (NODES - 1);
    localparam int NPATH  = NCH + MC * (MT - 1);
    localparam int PIDX_W = $clog2(NPATH + 1);

    // R5 channel numbering, written from the requirement
    function automatic int b_chan(int p);
        return (p < NCH) ? p : (p - NCH) / (MT - 1);
    endfunction
    function automatic int b_dst(int p);
        return b_chan(p) / (NODES - 1);
    endfunction
    function automatic int b_src(int p);
        int r;
        r = b_chan(p) % (NODES - 1);
        return (r < b_dst(p)) ? r : r + 1;
    endfunction
    function automatic int b_maxt();
        int best;
        best = 0;
        for (int k = 0; k < NODES; k++) begin
            int c;
            c = 0;
            for (int p = 0; p < NPATH; p++)
                if (b_dst(p) == k) c++;
            if (c > best) best = c;
        end
        return best;
    endfunction

    // R6 latency
    localparam int LAT = $clog2(b_maxt()) + 2;

    // R3 path arithmetic
    function automatic int contrib(int x, int s, int h);
        longint v;
        logic signed [13:0] tr;
        v  = longint'(x) * longint'(s);
        v  = v <<< h;
        v  = v >>> 8;
        tr = v[13:0];
        return int'(tr);
    endfunction

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NODES-1:0][11:0]  src_sample = '0;
    logic                    wr_en = 1'b0;
    logic [PIDX_W-1:0]       wr_path = '0;
    logic [3:0]              wr_delay = '0;
    logic [7:0]              wr_scale = '0;
    logic [3:0]              wr_shift = '0;
    logic [NODES-1:0][13:0]  dst_sample;
    logic [NODES-1:0]        dst_ovf;

    always #4 clk = ~clk;

    chsim_path_combiner u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_sample(src_sample),
        .wr_en     (wr_en),
        .wr_path   (wr_path),
        .wr_delay  (wr_delay),
        .wr_scale  (wr_scale),
        .wr_shift  (wr_shift),
        .dst_sample(dst_sample),
        .dst_ovf   (dst_ovf)
    );

    typedef struct {
        int                     due;
        logic [NODES-1:0][13:0] v;
        logic [NODES-1:0]       f;
    } exp_t;
    typedef struct {
        int act;
        int p;
        int d;
        int s;
        int h;
    } wr_t;

    exp_t  q[$];
    string tq[$];
    wr_t   pend[$];
    int    hist_m [16][NODES];
    int    m_dly [NPATH];
    int    m_scl [NPATH];
    int    m_shf [NPATH];
    logic  [NODES-1:0] m_flag = '0;
    string cur_tag = "R1";
    int    edge_n = 0;
    int    n_cmp = 0;
    int    n_bad = 0;

    initial begin
        for (int i = 0; i < 16; i++)
            for (int n = 0; n < NODES; n++)
                hist_m[i][n] = 0;
        for (int p = 0; p < NPATH; p++) begin
            m_dly[p] = 0;
            m_scl[p] = 0;
            m_shf[p] = 0;
        end
    end

    always @(posedge clk)
        if (!rst) edge_n <= edge_n + 1;

    // Driver: one sample per cycle, optional write, expected item pushed.
    task automatic step(input bit w, input int p, input int d, input int s, input int h,
                        input int amp, input logic [NODES-1:0] act);
        int   t;
        exp_t e;
        @(negedge clk);
        t = edge_n + 1;
        for (int n = 0; n < NODES; n++) begin
            int x;
            x = act[n] ? (int'($urandom_range(2 * amp)) - amp) : 0;
            src_sample[n] = 12'(x);
            hist_m[t & 15][n] = x;
        end
        wr_en    = w;
        wr_path  = PIDX_W'(p);
        wr_delay = 4'(d);
        wr_scale = 8'(s);
        wr_shift = 4'(h);
        if (w && p < NPATH)
            pend.push_back('{t + 2, p, d, s, h});
        while (pend.size() > 0 && pend[0].act <= t) begin
            wr_t pw;
            pw = pend.pop_front();
            m_dly[pw.p] = pw.d;
            m_scl[pw.p] = pw.s;
            m_shf[pw.p] = pw.h;
        end
        for (int k = 0; k < NODES; k++) begin
            int sum;
            sum = 0;
            for (int pp = 0; pp < NPATH; pp++)
                if (b_dst(pp) == k)
                    sum += contrib(hist_m[(t - m_dly[pp]) & 15][b_src(pp)], m_scl[pp], m_shf[pp]);
            if (sum > 8191) begin
                sum = 8191;
                m_flag[k] = 1'b1;
            end else if (sum < -8192) begin
                sum = -8192;
                m_flag[k] = 1'b1;
            end
            e.v[k] = 14'(sum);
        end
        e.f   = m_flag;
        e.due = t + LAT;
        q.push_back(e);
        tq.push_back(cur_tag);
    endtask

    task automatic wr(input int p, input int d, input int s, input int h,
                      input int amp, input logic [NODES-1:0] act);
        step(1'b1, p, d, s, h, amp, act);
    endtask

    task automatic run(input int cnt, input int amp, input logic [NODES-1:0] act);
        for (int i = 0; i < cnt; i++)
            step(1'b0, 0, 0, 0, 0, amp, act);
    endtask

    // Monitor: scoreboard comparison when an expected item falls due.
    always @(negedge clk) begin
        if (!rst && q.size() > 0 && q[0].due == edge_n) begin
            exp_t  e;
            string tg;
            e  = q.pop_front();
            tg = tq.pop_front();
            for (int k = 0; k < NODES; k++) begin
                n_cmp++;
                if (dst_sample[k] !== e.v[k] || dst_ovf[k] !== e.f[k]) begin
                    n_bad++;
                    $display("FAIL %s dest %0d edge %0d: actual %0d ovf %0b, expected %0d ovf %0b",
                             tg, k, edge_n, $signed(dst_sample[k]), dst_ovf[k],
                             $signed(e.v[k]), e.f[k]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog: actual run still busy, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < NODES; k++) begin
            n_cmp++;
            if (dst_sample[k] !== 14'd0 || dst_ovf[k] !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 dest %0d: actual %0d ovf %0b, expected 0 ovf 0",
                         k, $signed(dst_sample[k]), dst_ovf[k]);
            end
        end
        cur_tag = "R1";
        run(8, 900, 4'b1111);

        // R3 / R6: unity gain on every first tap, written while streaming
        cur_tag = "R3/R6";
        for (int p = 0; p < NCH; p++)
            wr(p, 0, 128, 1, 500, 4'b1111);
        run(20, 1000, 4'b1111);

        // R3: distinct fine and coarse settings
        cur_tag = "R3";
        for (int p = 0; p < NCH; p++)
            wr(p, 0, 37 + 13 * p, p % 3, 700, 4'b1111);
        run(24, 700, 4'b1111);

        // R2: single active source never reaches itself
        cur_tag = "R2";
        run(12, 2000, 4'b0010);
        run(12, 2000, 4'b0001);

        // R4: delays across the whole range, including 0 and 15
        cur_tag = "R4";
        for (int p = 0; p < NCH; p++)
            wr(p, (p * 5) % 16, 37 + 13 * p, p % 3, 600, 4'b1111);
        run(40, 700, 4'b1111);

        // R5: extra taps of the multipath channels
        cur_tag = "R5";
        for (int p = NCH; p < NPATH; p++)
            wr(p, 7 + (p - NCH), 64 + 16 * (p - NCH), 0, 600, 4'b1111);
        run(30, 600, 4'b1111);
        run(10, 1500, 4'b0110);

        // R9: back-to-back and spaced writes while streaming
        cur_tag = "R9";
        for (int i = 0; i < 8; i++)
            wr(i % 4, i, 40 + 20 * i, i % 2, 700, 4'b1111);
        for (int i = 0; i < 6; i++) begin
            wr(4 + i, 15 - i, 90, 1, 700, 4'b1111);
            run(1, 700, 4'b1111);
        end
        run(20, 700, 4'b1111);

        // R10: out-of-range indexes with huge gain
        cur_tag = "R10";
        for (int p = NPATH; p < (1 << PIDX_W); p++)
            wr(p, 3, 255, 15, 700, 4'b1111);
        run(16, 700, 4'b1111);

        // R7 / R8: gain 4 on every first tap into destination 2
        cur_tag = "R7/R8";
        for (int j = 0; j < NODES - 1; j++)
            wr(2 * (NODES - 1) + j, 0, 128, 3, 300, 4'b1111);
        run(30, 2000, 4'b1111);
        for (int j = 0; j < NODES - 1; j++)
            wr(2 * (NODES - 1) + j, 0, 128, 0, 300, 4'b1111);
        cur_tag = "R8";
        run(20, 400, 4'b1111);

        cur_tag = "R6";
        run(4, 0, 4'b0000);
        repeat (LAT + 3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule